// File: doc/BRIEF.md
# Operand-Order Branch Condition Unit

This block decides conditional branches for a small processor. It receives the values of two registers together with their 2-bit register indices, a 2-bit condition code, a signed 7-bit branch offset and the address of the branch. It returns a registered taken flag, a flag that marks the encoding as a real conditional branch, and the address of the next instruction.

Only four base conditions have codes. The inverse or mirrored form of each condition has no code of its own. It is selected by writing the register fields in the opposite order. A lower index in the first field selects the base condition. A higher index selects its counterpart. Equal indices belong to another instruction, so the unit then reports no branch and moves on to the next sequential instruction.

The comparison logic is purely combinational. A single register stage, loaded only when `eval_en` is high, captures its result. The reset input is asynchronous and active low. Internally, its release is synchronised to the clock over two stages.

Top module: `bcu_branch_unit`

## Requirements
- R1: While reset is held, and until the internal reset is released, `taken`, `is_branch` and `next_pc` all read zero.
- R2: Condition code 2'b00 compares `val_a` with `val_b`. With `idx_a < idx_b` the branch is taken when they are equal. With `idx_a > idx_b` it is taken when they differ.
- R3: Condition code 2'b01 forms `val_a & val_b`. With `idx_a < idx_b` the branch is taken when the result is nonzero. With `idx_a > idx_b` it is taken when the result is zero.
- R4: Condition code 2'b10 is a two's-complement comparison. With `idx_a < idx_b` the branch is taken when `val_a < val_b`. With `idx_a > idx_b` it is taken when `val_a > val_b`.
- R5: Condition code 2'b11 is an unsigned comparison. With `idx_a < idx_b` the branch is taken when `val_a < val_b`. With `idx_a > idx_b` it is taken when `val_a > val_b`.
- R6: When `idx_a == idx_b`, `is_branch` and `taken` are 0 and `next_pc` is `pc + 2`, for every condition code and value.
- R7: A taken branch gives `next_pc = pc + 2 + sign-extended offset`, computed modulo 2^ADDR_W. Bit 6 of `offset` is its sign.
- R8: A branch that is not taken gives `next_pc = pc + 2`, computed modulo 2^ADDR_W.
- R9: Outputs reflect the inputs sampled at the previous rising clock edge at which `eval_en` was 1. When `eval_en` is 0, the outputs keep their values.
- R10: The decision depends only on the register values and the order of the indices. Any two index pairs with the same order give the same result for the same values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eval_en | input | 1 | Loads the output registers with a new evaluation |
| idx_a | input | 2 | Index of the first register field |
| idx_b | input | 2 | Index of the second register field |
| val_a | input | DATA_W | Value of the first register |
| val_b | input | DATA_W | Value of the second register |
| cond | input | 2 | Base condition code |
| offset | input | 7 | Signed branch offset in bytes |
| pc | input | ADDR_W | Address of the branch instruction |
| taken | output | 1 | Branch taken |
| is_branch | output | 1 | Encoding is a conditional branch (indices differ) |
| next_pc | output | ADDR_W | Address of the next instruction |

## Verification
The bench uses the default widths, DATA_W = 16 and ADDR_W = 16. At these widths the operands 0x7FFF and 0x8000 are easy to reach. They sit on opposite sides of the signed boundary but not the unsigned one, so signed and unsigned comparisons give different answers for them. The 16-bit address also makes wrap-around of the target easy to drive, both past 0xFFFF and below zero. Randomised value pairs are run through every ordered index pair and every code, so all twelve distinct index pairs are exercised with each polarity.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
  typedef enum logic [1:0] {
    CC_EQ   = 2'b00,
    CC_TEST = 2'b01,
    CC_SLT  = 2'b10,
    CC_ULT  = 2'b11
  } cc_e;

  localparam int unsigned IDX_W       = 2;
  localparam int unsigned OFF_W       = 7;
  localparam int unsigned INSTR_BYTES = 2;
endpackage

// File: rtl/bcu_rst_sync.sv
module bcu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bcu_cond_eval.sv
module bcu_cond_eval
  import bcu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [IDX_W-1:0]  idx_a,
  input  logic [IDX_W-1:0]  idx_b,
  input  logic [DATA_W-1:0] val_a,
  input  logic [DATA_W-1:0] val_b,
  input  logic [1:0]        cond,
  output logic              is_br,
  output logic              hit
);
  logic mirrored;
  logic eq_r, tst_r, slt_r, sgt_r, ult_r, ugt_r;
  logic raw;

  assign is_br    = (idx_a != idx_b);
  assign mirrored = (idx_a > idx_b);

  assign eq_r  = (val_a == val_b);
  assign tst_r = |(val_a & val_b);
  assign slt_r = ($signed(val_a) < $signed(val_b));
  assign sgt_r = ($signed(val_b) < $signed(val_a));
  assign ult_r = (val_a < val_b);
  assign ugt_r = (val_b < val_a);

  always_comb begin
    unique case (cc_e'(cond))
      CC_EQ:   raw = mirrored ? !eq_r  : eq_r;
      CC_TEST: raw = mirrored ? !tst_r : tst_r;
      CC_SLT:  raw = mirrored ? sgt_r  : slt_r;
      CC_ULT:  raw = mirrored ? ugt_r  : ult_r;
      default: raw = 1'b0;
    endcase
  end

  assign hit = is_br & raw;
endmodule

// File: rtl/bcu_target.sv
module bcu_target
  import bcu_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [OFF_W-1:0]  offset,
  input  logic              take,
  output logic [ADDR_W-1:0] next_pc
);
  localparam int unsigned EXT_W = (ADDR_W > OFF_W) ? ADDR_W - OFF_W : 0;

  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] off_ext;

  generate
    if (EXT_W > 0) begin : g_sext
      assign off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
    end else begin : g_trunc
      assign off_ext = offset[ADDR_W-1:0];
    end
  endgenerate

  assign seq_pc  = pc + ADDR_W'(INSTR_BYTES);
  assign next_pc = take ? (seq_pc + off_ext) : seq_pc;
endmodule

// File: rtl/bcu_branch_unit.sv
module bcu_branch_unit
  import bcu_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval_en,
  input  logic [1:0]        idx_a,
  input  logic [1:0]        idx_b,
  input  logic [DATA_W-1:0] val_a,
  input  logic [DATA_W-1:0] val_b,
  input  logic [1:0]        cond,
  input  logic [6:0]        offset,
  input  logic [ADDR_W-1:0] pc,
  output logic              taken,
  output logic              is_branch,
  output logic [ADDR_W-1:0] next_pc
);
  logic              rst_int_n;
  logic              br_d, hit_d;
  logic [ADDR_W-1:0] npc_d;
  logic              taken_q, br_q;
  logic [ADDR_W-1:0] npc_q;
  logic              taken_nx, br_nx;
  logic [ADDR_W-1:0] npc_nx;

  bcu_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  bcu_cond_eval #(.DATA_W(DATA_W)) u_cond (
    .idx_a (idx_a),
    .idx_b (idx_b),
    .val_a (val_a),
    .val_b (val_b),
    .cond  (cond),
    .is_br (br_d),
    .hit   (hit_d)
  );

  bcu_target #(.ADDR_W(ADDR_W)) u_tgt (
    .pc      (pc),
    .offset  (offset),
    .take    (hit_d),
    .next_pc (npc_d)
  );

  always_comb begin
    taken_nx = taken_q;
    br_nx    = br_q;
    npc_nx   = npc_q;
    if (eval_en) begin
      taken_nx = hit_d;
      br_nx    = br_d;
      npc_nx   = npc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      taken_q <= 1'b0;
      br_q    <= 1'b0;
      npc_q   <= '0;
    end else begin
      taken_q <= taken_nx;
      br_q    <= br_nx;
      npc_q   <= npc_nx;
    end
  end

  assign taken     = taken_q;
  assign is_branch = br_q;
  assign next_pc   = npc_q;
endmodule

// File: rtl/bcu_branch_unit_chk.sv
module bcu_branch_unit_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_q,
  input logic              eval_en,
  input logic [1:0]        idx_a,
  input logic [1:0]        idx_b,
  input logic [DATA_W-1:0] val_a,
  input logic [DATA_W-1:0] val_b,
  input logic [1:0]        cond,
  input logic [6:0]        offset,
  input logic [ADDR_W-1:0] pc,
  input logic              taken,
  input logic              is_branch,
  input logic [ADDR_W-1:0] next_pc
);
  logic [ADDR_W-1:0] off_sx;
  assign off_sx = ADDR_W'($signed(offset));

  // R1
  r1_reset_zero_chk: assert property (@(posedge clk)
    !rst_q |-> (!taken && !is_branch && next_pc == '0));

  // R6
  r6_same_idx_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ($past(rst_q) && $past(eval_en) && $past(idx_a == idx_b)) |-> (!taken && !is_branch));

  // R8
  r8_seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ($past(rst_q) && $past(eval_en) && !taken) |-> (next_pc == $past(pc) + ADDR_W'(2)));

  // R7
  r7_target_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ($past(rst_q) && $past(eval_en) && taken) |-> (next_pc == $past(pc) + ADDR_W'(2) + $past(off_sx)));

  // R9
  r9_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ($past(rst_q) && !$past(eval_en)) |-> ($stable(taken) && $stable(is_branch) && $stable(next_pc)));

  // R2
  r2_eq_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ($past(rst_q) && $past(eval_en) && $past(cond == 2'b00) && $past(idx_a < idx_b))
      |-> (taken == $past(val_a == val_b)));
endmodule

bind bcu_branch_unit bcu_branch_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_q     (rst_int_n),
  .eval_en   (eval_en),
  .idx_a     (idx_a),
  .idx_b     (idx_b),
  .val_a     (val_a),
  .val_b     (val_b),
  .cond      (cond),
  .offset    (offset),
  .pc        (pc),
  .taken     (taken),
  .is_branch (is_branch),
  .next_pc   (next_pc)
);

// File: tb/tb_bcu_branch_unit.sv
`timescale 1ns/1ps
module tb_bcu_branch_unit;
  localparam int DW = 16;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          eval_en;
  logic [1:0]    idx_a, idx_b, cond;
  logic [DW-1:0] val_a, val_b;
  logic [6:0]    offset;
  logic [AW-1:0] pc;
  logic          taken, is_branch;
  logic [AW-1:0] next_pc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bcu_branch_unit #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .eval_en(eval_en),
    .idx_a(idx_a), .idx_b(idx_b), .val_a(val_a), .val_b(val_b),
    .cond(cond), .offset(offset), .pc(pc),
    .taken(taken), .is_branch(is_branch), .next_pc(next_pc)
  );

  function automatic bit model_hit(input logic [1:0] ia, input logic [1:0] ib,
                                   input logic [DW-1:0] a, input logic [DW-1:0] b,
                                   input logic [1:0] cc);
    bit flip;
    if (ia == ib) return 0;
    flip = (ia > ib);
    case (cc)
      2'b00: return flip ? (a != b) : (a == b);
      2'b01: return flip ? ((a & b) == 0) : ((a & b) != 0);
      2'b10: return flip ? ($signed(a) > $signed(b)) : ($signed(a) < $signed(b));
      default: return flip ? (a > b) : (a < b);
    endcase
  endfunction

  function automatic logic [AW-1:0] model_pc(input bit t, input logic [AW-1:0] p,
                                             input logic [6:0] off);
    logic [AW-1:0] s;
    s = p + 16'd2;
    if (t) s = s + {{(AW-7){off[6]}}, off};
    return s;
  endfunction

  task automatic check(input string req, input bit exp_t, input bit exp_b,
                       input logic [AW-1:0] exp_pc);
    checks++;
    if (taken !== exp_t || is_branch !== exp_b || next_pc !== exp_pc) begin
      errors++;
      $display("FAIL %s: got taken=%0b br=%0b pc=%h, expected taken=%0b br=%0b pc=%h",
               req, taken, is_branch, next_pc, exp_t, exp_b, exp_pc);
    end
  endtask

  task automatic eval_one(input string req, input logic [1:0] ia, input logic [1:0] ib,
                          input logic [DW-1:0] a, input logic [DW-1:0] b,
                          input logic [1:0] cc, input logic [6:0] off,
                          input logic [AW-1:0] p);
    bit t;
    @(negedge clk);
    eval_en = 1; idx_a = ia; idx_b = ib; val_a = a; val_b = b;
    cond = cc; offset = off; pc = p;
    @(negedge clk);
    eval_en = 0;
    t = model_hit(ia, ib, a, b, cc);
    check(req, t, ia != ib, model_pc(t, p, off));
  endtask

  task automatic t_reset;
    rst_n = 0; eval_en = 1; idx_a = 0; idx_b = 1; val_a = 0; val_b = 0;
    cond = 0; offset = 7'd5; pc = 16'h100;
    repeat (3) @(negedge clk);
    check("R1 in reset", 0, 0, '0);
    rst_n = 1;
    @(negedge clk);
    check("R1 sync release", 0, 0, '0);
    eval_en = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_eq;
    eval_one("R2 eq equal", 2'd0, 2'd1, 16'h1234, 16'h1234, 2'b00, 7'd4, 16'h0200);
    eval_one("R2 eq differ", 2'd0, 2'd1, 16'h1234, 16'h1235, 2'b00, 7'd4, 16'h0200);
    eval_one("R2 ne differ", 2'd3, 2'd1, 16'h1234, 16'h1235, 2'b00, 7'd4, 16'h0200);
    eval_one("R2 ne equal", 2'd3, 2'd1, 16'h00AA, 16'h00AA, 2'b00, 7'd4, 16'h0200);
  endtask

  task automatic t_test;
    eval_one("R3 test set", 2'd1, 2'd2, 16'h0F00, 16'h0100, 2'b01, 7'd8, 16'h0300);
    eval_one("R3 test clear", 2'd1, 2'd2, 16'h0F00, 16'h00F0, 2'b01, 7'd8, 16'h0300);
    eval_one("R3 testn clear", 2'd2, 2'd1, 16'h0F00, 16'h00F0, 2'b01, 7'd8, 16'h0300);
    eval_one("R3 testn set", 2'd2, 2'd1, 16'h8000, 16'h8000, 2'b01, 7'd8, 16'h0300);
  endtask

  task automatic t_lt;
    eval_one("R4 slt boundary", 2'd0, 2'd3, 16'h8000, 16'h7FFF, 2'b10, 7'd2, 16'h0400);
    eval_one("R4 sgt boundary", 2'd3, 2'd0, 16'h7FFF, 16'h8000, 2'b10, 7'd2, 16'h0400);
    eval_one("R4 sgt equal", 2'd3, 2'd0, 16'h0005, 16'h0005, 2'b10, 7'd2, 16'h0400);
    eval_one("R5 ult boundary", 2'd0, 2'd3, 16'h7FFF, 16'h8000, 2'b11, 7'd2, 16'h0400);
    eval_one("R5 ult reversed", 2'd0, 2'd3, 16'h8000, 16'h7FFF, 2'b11, 7'd2, 16'h0400);
    eval_one("R5 ugt", 2'd2, 2'd0, 16'hFFFF, 16'h0000, 2'b11, 7'd2, 16'h0400);
  endtask

  task automatic t_same_idx;
    for (int c = 0; c < 4; c++)
      eval_one("R6 same index", 2'(c), 2'(c), 16'h0000, 16'h0000, 2'(c), 7'h3F, 16'h0500);
  endtask

  task automatic t_offsets;
    eval_one("R7 max fwd", 2'd0, 2'd1, 16'h0001, 16'h0001, 2'b00, 7'h3F, 16'h1000);
    eval_one("R7 max back", 2'd0, 2'd1, 16'h0001, 16'h0001, 2'b00, 7'h40, 16'h1000);
    eval_one("R7 wrap high", 2'd0, 2'd1, 16'h0001, 16'h0001, 2'b00, 7'h10, 16'hFFF8);
    eval_one("R7 wrap low", 2'd0, 2'd1, 16'h0001, 16'h0001, 2'b00, 7'h70, 16'h0004);
    eval_one("R8 wrap seq", 2'd0, 2'd1, 16'h0001, 16'h0002, 2'b00, 7'h10, 16'hFFFF);
  endtask

  task automatic t_hold;
    logic t0, b0;
    logic [AW-1:0] p0;
    eval_one("R9 load", 2'd1, 2'd3, 16'h0002, 16'h0009, 2'b11, 7'd12, 16'h2000);
    t0 = taken; b0 = is_branch; p0 = next_pc;
    @(negedge clk);
    eval_en = 0; idx_a = 2'd2; idx_b = 2'd2; val_a = 16'h9; val_b = 16'h1;
    pc = 16'h7777; offset = 7'h55;
    repeat (3) @(negedge clk);
    check("R9 hold", t0, b0, p0);
  endtask

  task automatic t_random;
    for (int i = 0; i < 120; i++) begin
      logic [DW-1:0] a, b;
      a = DW'($urandom);
      b = (i % 5 == 0) ? a : DW'($urandom);
      for (int ia = 0; ia < 4; ia++)
        for (int ib = 0; ib < 4; ib++)
          if (ia != ib)
            eval_one("R10 random", 2'(ia), 2'(ib), a, b, 2'(i % 4),
                     7'($urandom), AW'($urandom));
    end
  endtask

  initial begin
    t_reset();
    t_eq();
    t_test();
    t_lt();
    t_same_idx();
    t_offsets();
    t_hold();
    t_random();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got running, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule